// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block is the interrupt unit of a small 8-bit microcontroller core. It watches six request pulses: two external pins, two timer overflows, a time-base tick and a real-time-clock tick. Each pulse latches a sticky pending flag. The flags, the per-source enables and a global master enable sit in two byte-wide control registers at fixed data-memory addresses. The core reads and writes these registers through a simple byte port.

Arbitration happens only on a rising edge of the instruction-cycle phase strobe. At that edge the block looks for any pending source whose own enable is set. The master enable must also be set and the core's call stack must not be full. If a source qualifies, the highest-priority one wins. The block then pulses an accept line for one clock and presents that source's vector address. In the same clock it clears the master enable and the winning flag, so nothing else is taken while the service routine runs. A return-with-enable strobe from the core sets the master enable again, and so does a software write. A plain return strobe does not change it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00, and `irq_accept` and `irq_vector` are 0.
- R2: Register 0 is at address 0x0B. It holds bit0 master enable, bits1..3 the enables of ext0/ext1/timer0, and bits4..6 their flags. Register 1 is at address 0x1E. It holds bits0..2 the enables of timer1/timebase/rtc and bits4..6 their flags. Unused bits and other addresses read 0, and writes may set or clear any flag.
- R3: A one-clock pulse on `src_pulse[i]` sets flag i on the next clock edge. The flag stays set until it is serviced or software writes it to 0. The source indices are 0 ext0, 1 ext1, 2 timer0, 3 timer1, 4 timebase and 5 rtc.
- R4: When a source pulse and a software write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R5: Arbitration happens only in a cycle where `phase_stb` is 1 after being 0 in the previous cycle. `irq_accept` is high in the following cycle. A pending request is not taken while the strobe stays high.
- R6: A source is taken only if its flag, its enable and the master enable are all 1.
- R7: Among qualifying sources, the lowest index wins. The vector of source i is 0x04 + 4*i.
- R8: On acceptance, `irq_accept` is high for exactly one clock. In that same clock the master enable and only the winning flag are cleared, and `irq_vector` holds its value until the next acceptance.
- R9: While `stack_full` is 1 at the strobe edge, no request is taken and the flags are kept.
- R10: `reti_stb` sets the master enable. `ret_stb` leaves it unchanged.
- R11: Software setting the master enable and a source enable inside a service routine allows a nested acceptance at the next strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 6 | Request pulses, index 0 highest priority |
| phase_stb | input | 1 | Instruction-cycle phase strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| stack_full | input | 1 | Core call stack has no free entry |
| ret_stb | input | 1 | Plain return executed |
| reti_stb | input | 1 | Return-with-enable executed |
| irq_accept | output | 1 | One-clock acceptance pulse |
| irq_vector | output | 8 | Vector address of the last accepted source |

## Verification
A flag or enable bit stored in the wrong place shows up on the read port in the cycle after the write or pulse. It also shows up at the next strobe edge, as a missing acceptance or a wrong vector. If the master enable is not cleared when a request is taken, the first strobe edge after acceptance gives a second `irq_accept`. The priority test drains all six pending sources one at a time. After each drain the bench reads both registers, so a wrong cleared flag is seen one clock after `irq_accept`.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   localparam int SRC_N = 6;

   // sources 0..2 live in register 0, sources 3..5 in register 1
   function automatic bit src_in_reg1(input int idx);
      return idx >= 3;
   endfunction

   function automatic int en_pos(input int idx);
      return (idx < 3) ? idx + 1 : idx - 3;
   endfunction

   function automatic int fl_pos(input int idx);
      return (idx < 3) ? idx + 4 : idx + 1;
   endfunction

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
   import prio_irq_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter logic [ADDR_W-1:0] REG0_ADDR = 8'h0B,
   parameter logic [ADDR_W-1:0] REG1_ADDR = 8'h1E
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [SRC_N-1:0]  src_pulse,
   input  logic              take,
   input  logic [SRC_N-1:0]  take_grant,
   input  logic              reti_stb,
   output logic              mie,
   output logic [SRC_N-1:0]  en,
   output logic [SRC_N-1:0]  fl
);

   initial begin
      if (DATA_W < 7) $error("prio_irq_regs: DATA_W must hold bit 6");
      if (REG0_ADDR == REG1_ADDR) $error("prio_irq_regs: register addresses collide");
   end

   logic wr0, wr1;
   assign wr0 = wr_en && (wr_addr == REG0_ADDR);
   assign wr1 = wr_en && (wr_addr == REG1_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mie <= 1'b0;
      else if (take)     mie <= 1'b0;
      else if (reti_stb) mie <= 1'b1;
      else if (wr0)      mie <= wr_data[0];
   end

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      localparam bit HI  = src_in_reg1(i);
      localparam int EBP = en_pos(i);
      localparam int FBP = fl_pos(i);
      logic hit;
      assign hit = HI ? wr1 : wr0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   en[i] <= 1'b0;
         else if (hit) en[i] <= wr_data[EBP];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  fl[i] <= 1'b0;
         else if (src_pulse[i])       fl[i] <= 1'b1;
         else if (take && take_grant[i]) fl[i] <= 1'b0;
         else if (hit)                fl[i] <= wr_data[FBP];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == REG0_ADDR) begin
         rd_data[0] = mie;
         for (int i = 0; i < 3; i++) begin
            rd_data[en_pos(i)] = en[i];
            rd_data[fl_pos(i)] = fl[i];
         end
      end else if (rd_addr == REG1_ADDR) begin
         for (int i = 3; i < SRC_N; i++) begin
            rd_data[en_pos(i)] = en[i];
            rd_data[fl_pos(i)] = fl[i];
         end
      end
   end

   // R4
   hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pulse != '0) |=> ((fl & $past(src_pulse)) == $past(src_pulse)));

   // R10
   reti_sets_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_stb && !take) |=> mie);

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
   parameter int N         = 6,
   parameter int VEC_W     = 8,
   parameter int VEC_BASE  = 4,
   parameter int VEC_STEP  = 4
)(
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic             any,
   output logic [VEC_W-1:0] vec
);

   initial begin
      if (VEC_BASE + VEC_STEP * (N - 1) >= (1 << VEC_W))
         $error("prio_irq_arb: vectors do not fit VEC_W");
   end

   logic [N:0] blk;
   assign blk[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = req[i] & ~blk[i];
      assign blk[i+1]  = blk[i] | req[i];
   end

   assign any = blk[N];

   always_comb begin
      vec = '0;
      for (int i = 0; i < N; i++)
         if (grant[i]) vec = vec | VEC_W'(VEC_BASE + VEC_STEP * i);
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4,
   parameter logic [ADDR_W-1:0] REG0_ADDR = 8'h0B,
   parameter logic [ADDR_W-1:0] REG1_ADDR = 8'h1E
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [5:0]        src_pulse,
   input  logic              phase_stb,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              stack_full,
   input  logic              ret_stb,
   input  logic              reti_stb,
   output logic              irq_accept,
   output logic [VEC_W-1:0]  irq_vector
);

   logic              phase_q;
   logic              stb_edge;
   logic              mie;
   logic [SRC_N-1:0]  en, fl, grant;
   logic              any;
   logic              take;
   logic [VEC_W-1:0]  vec_c;

   prio_irq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .REG0_ADDR(REG0_ADDR), .REG1_ADDR(REG1_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .src_pulse(src_pulse), .take(take), .take_grant(grant),
      .reti_stb(reti_stb),
      .mie(mie), .en(en), .fl(fl)
   );

   prio_irq_arb #(
      .N(SRC_N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
   ) u_arb (
      .req(fl & en), .grant(grant), .any(any), .vec(vec_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= 1'b0;
      else        phase_q <= phase_stb;
   end

   assign stb_edge = phase_stb & ~phase_q;
   assign take     = stb_edge & mie & ~stack_full & any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_accept <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_accept <= take;
         if (take) irq_vector <= vec_c;
      end
   end

   // R8
   accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |=> !irq_accept);

   // R8
   accept_clears_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |-> !mie);

   // R6
   accept_needs_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |-> $past(mie));

   // R9
   accept_stack_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |-> !$past(stack_full));

   // R5
   accept_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |-> ($past(phase_stb) && phase_q));

   // R10
   ret_keeps_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_stb && !reti_stb && !take && !(wr_en && wr_addr == REG0_ADDR)) |=> $stable(mie));

   // R8
   vector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_accept |-> $stable(irq_vector));

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] src_pulse = '0;
   logic       phase_stb = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       stack_full = 1'b0;
   logic       ret_stb = 1'b0;
   logic       reti_stb = 1'b0;
   logic       irq_accept;
   logic [7:0] irq_vector;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   localparam logic [7:0] A0 = 8'h0B;
   localparam logic [7:0] A1 = 8'h1E;

   always #2 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .phase_stb(phase_stb),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .stack_full(stack_full),
      .ret_stb(ret_stb), .reti_stb(reti_stb),
      .irq_accept(irq_accept), .irq_vector(irq_vector)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      rd_addr = a; #0.5; d = rd_data;
   endtask

   task automatic pulse(input logic [5:0] m);
      src_pulse = m; step(); src_pulse = '0;
   endtask

   // raise the strobe for one clock, report accept and vector seen after the edge
   task automatic strobe(output logic acc, output logic [7:0] vec);
      phase_stb = 1'b1; step();
      acc = irq_accept; vec = irq_vector;
      phase_stb = 1'b0; step();
      check("R8 accept one clock", {7'b0, irq_accept}, 8'h00);
   endtask

   function automatic logic [7:0] r0(input logic m, input logic [5:0] e, input logic [5:0] f);
      return {1'b0, f[2:0], e[2:0], m};
   endfunction

   function automatic logic [7:0] r1(input logic [5:0] e, input logic [5:0] f);
      return {1'b0, f[5:3], 1'b0, e[5:3]};
   endfunction

   task automatic clear_all();
      wr(A0, 8'h00); wr(A1, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A0, d); check("R1 reg0 reset", d, 8'h00);
      rd(A1, d); check("R1 reg1 reset", d, 8'h00);
      check("R1 accept reset", {7'b0, irq_accept}, 8'h00);
      check("R1 vector reset", irq_vector, 8'h00);
   endtask

   task automatic t_layout();
      logic [7:0] d;
      wr(A0, 8'hFF); rd(A0, d); check("R2 reg0 unused bits", d, 8'h7F);
      wr(A1, 8'hFF); rd(A1, d); check("R2 reg1 unused bits", d, 8'h77);
      rd(8'h0C, d); check("R2 other address", d, 8'h00);
      wr(A0, 8'h0A); rd(A0, d); check("R2 reg0 enables", d, r0(1'b0, 6'b000101, 6'b0));
      rd(A1, d); check("R2 reg1 untouched", d, 8'h77);
      clear_all();
      rd(A1, d); check("R2 sw clear", d, 8'h00);
   endtask

   task automatic t_sticky();
      logic [7:0] d;
      pulse(6'b001000);
      repeat (5) step();
      rd(A1, d); check("R3 timer1 flag sticky", d, r1(6'b0, 6'b001000));
      pulse(6'b000100);
      rd(A0, d); check("R3 timer0 flag", d, r0(1'b0, 6'b0, 6'b000100));
      clear_all();
      rd(A1, d); check("R3 sw clear", d, 8'h00);
   endtask

   task automatic t_hw_wins();
      logic [7:0] d;
      pulse(6'b100000);
      src_pulse = 6'b100000;
      wr(A1, 8'h00);
      src_pulse = '0;
      rd(A1, d); check("R4 set beats clear", d, r1(6'b0, 6'b100000));
      clear_all();
   endtask

   task automatic t_enable();
      logic acc; logic [7:0] v;
      pulse(6'b000001);
      wr(A0, r0(1'b0, 6'b000001, 6'b000001));
      strobe(acc, v); check("R6 no master enable", {7'b0, acc}, 8'h00);
      wr(A0, r0(1'b1, 6'b000000, 6'b000001));
      strobe(acc, v); check("R6 no source enable", {7'b0, acc}, 8'h00);
      wr(A0, r0(1'b1, 6'b000001, 6'b000001));
      strobe(acc, v);
      check("R6 accepted", {7'b0, acc}, 8'h01);
      check("R7 ext0 vector", v, 8'h04);
      clear_all();
   endtask

   task automatic t_edge();
      logic [7:0] d;
      wr(A0, r0(1'b1, 6'b000010, 6'b0));
      phase_stb = 1'b1; step(); step();
      pulse(6'b000010);
      repeat (3) begin
         step();
         check("R5 no accept while strobe high", {7'b0, irq_accept}, 8'h00);
      end
      phase_stb = 1'b0; step();
      phase_stb = 1'b1; step();
      check("R5 accept after new edge", {7'b0, irq_accept}, 8'h01);
      check("R7 ext1 vector", irq_vector, 8'h08);
      phase_stb = 1'b0; step();
      rd(A0, d); check("R8 flag and mie cleared", d, r0(1'b0, 6'b000010, 6'b0));
      clear_all();
   endtask

   task automatic t_priority();
      logic acc; logic [7:0] v, d;
      logic [5:0] left;
      wr(A0, r0(1'b1, 6'h3F, 6'h0));
      wr(A1, r1(6'h3F, 6'h0));
      pulse(6'h3F);
      left = 6'h3F;
      for (int k = 0; k < 6; k++) begin
         strobe(acc, v);
         check("R7 accept", {7'b0, acc}, 8'h01);
         check("R7 vector order", v, 8'(4 + 4 * k));
         left[k] = 1'b0;
         rd(A0, d); check("R8 reg0 after accept", d, r0(1'b0, 6'h3F, left));
         rd(A1, d); check("R8 reg1 after accept", d, r1(6'h3F, left));
         reti_stb = 1'b1; step(); reti_stb = 1'b0;
         rd(A0, d); check("R10 reti sets mie", d[0] ? 8'h01 : 8'h00, 8'h01);
      end
      strobe(acc, v); check("R8 vector held", v, 8'h18);
      clear_all();
   endtask

   task automatic t_ret();
      logic acc; logic [7:0] v, d;
      wr(A1, r1(6'b010000, 6'b0));
      wr(A0, r0(1'b1, 6'b0, 6'b0));
      pulse(6'b010000);
      strobe(acc, v); check("R7 timebase vector", v, 8'h14);
      pulse(6'b010000);
      ret_stb = 1'b1; step(); ret_stb = 1'b0;
      rd(A0, d); check("R10 ret keeps mie clear", d, 8'h00);
      strobe(acc, v); check("R10 no accept after ret", {7'b0, acc}, 8'h00);
      clear_all();
   endtask

   task automatic t_stack();
      logic acc; logic [7:0] v, d;
      wr(A1, r1(6'b100000, 6'b0));
      wr(A0, r0(1'b1, 6'b0, 6'b0));
      pulse(6'b100000);
      stack_full = 1'b1;
      strobe(acc, v); check("R9 blocked when stack full", {7'b0, acc}, 8'h00);
      rd(A1, d); check("R9 flag kept", d, r1(6'b100000, 6'b100000));
      stack_full = 1'b0;
      strobe(acc, v);
      check("R9 accepted after stack frees", {7'b0, acc}, 8'h01);
      check("R7 rtc vector", v, 8'h18);
      clear_all();
   endtask

   task automatic t_nest();
      logic acc; logic [7:0] v;
      wr(A0, r0(1'b1, 6'b000100, 6'b0));
      pulse(6'b000100);
      strobe(acc, v); check("R11 first accept", v, 8'h0C);
      pulse(6'b000001);
      strobe(acc, v); check("R11 held without re-enable", {7'b0, acc}, 8'h00);
      wr(A0, r0(1'b1, 6'b000101, 6'b000001));
      strobe(acc, v);
      check("R11 nested accept", {7'b0, acc}, 8'h01);
      check("R11 nested vector", v, 8'h04);
      clear_all();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_layout();
      t_sticky();
      t_hw_wins();
      t_enable();
      t_edge();
      t_priority();
      t_ret();
      t_stack();
      t_nest();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule